// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a stand-alone watchdog timer with a small register port. A down-counter, 12 bits wide by default, steps once per prescaled period of a low-speed tick. The low-speed tick reaches the block as an enable pulse, `lsi_tick_i`, in the main clock domain. The crossing into the slow domain is modelled as a fixed number of low-speed ticks of synchronization delay, and per-register busy flags make that delay visible.

Software controls the block only through 16-bit values written to a key register. One value opens the configuration registers for writing. A second value refreshes the counter. A third value starts the watchdog, and once started it cannot be stopped until system reset. Any other key value closes the configuration registers again.

When the counter steps past zero, the block raises a reset request for one cycle and reloads the counter. An optional early-warning flag is raised when the count steps down onto a programmable compare value. Two freeze inputs, one for stop mode and one for standby mode, halt the count while either of them is high.

Top module: `kwd_top`

## Requirements
- R1: After reset the prescaler code (offset 0x04) reads 0, the reload value (offset 0x08) reads 0xFFF, the early-warning register (offset 0x14) reads 0 and the status register (offset 0x0C) reads 0. Both `rst_req_o` and `ew_irq_o` are low.
- R2: Writing to offset 0x04, 0x08 or 0x14 has no effect unless the last value written to the key register (offset 0x00) was 0x5555. An ignored write changes neither the read-back value nor the status register.
- R3: Any key value other than 0x5555 closes the configuration registers, and this includes the refresh and start keys.
- R4: An accepted write to the prescaler, reload or early-warning register sets status bit 0, 1 or 3 respectively; status bit 2 always reads 0. The flag stays set for 4 low-speed ticks, and the register keeps reading its old value until the flag clears.
- R5: The counter does not run and no reset request is raised until 0xCCCC is written to the key register. After that the watchdog keeps running whatever is written.
- R6: After a start or a refresh, the first reset request comes exactly (reload + 1) × D ticks later, where D = 4 × 2^code and any prescaler code of 6 or above selects D = 256.
- R7: Writing 0xAAAA to the key register reloads the counter and restarts the prescaler. Refreshing more often than the timeout prevents any reset request.
- R8: The reset request is a one-cycle pulse. The counter reloads at the same edge, so expiries repeat with the period given in R6.
- R9: The early-warning register holds the compare value in bits 11:0 and the enable in bit 15. When enabled, `ew_irq_o` rises on the step that brings the count to the compare value and stays high. Writing 1 to bit 14 in an accepted write clears it at once. When the enable is 0, `ew_irq_o` stays low.
- R10: While `freeze_stop_i` or `freeze_standby_i` is high, the count and the prescaler hold. The expiry is delayed by exactly the number of frozen ticks.
- R11: Busy flags and configuration updates advance only on cycles where `lsi_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lsi_tick_i | input | 1 | Low-speed tick enable; one pulse per slow-clock period |
| freeze_stop_i | input | 1 | Holds the count while high (stop mode) |
| freeze_standby_i | input | 1 | Holds the count while high (standby mode) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| ew_irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 4-bit prescaler code capped at code 6, and a 4-tick synchronization delay. It holds `lsi_tick_i` high most of the time, so one tick equals one clock cycle. With small reload values and low prescaler codes, several full timeout periods, repeated expiries and the divide-by-256 cap fit within a few hundred cycles. The bench also holds the tick low for a stretch, which shows that busy flags and configuration updates stall with the slow clock.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int OFF_KEY  = 'h00;
  localparam int OFF_PSC  = 'h04;
  localparam int OFF_RLD  = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_EWC  = 'h14;

  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_START   = 16'hCCCC;

  // sync slot index per configuration register
  localparam int CH_PSC = 0;
  localparam int CH_RLD = 1;
  localparam int CH_EWC = 2;
  localparam int N_CH   = 3;
endpackage

// File: rtl/kwd_sync_slot.sv
module kwd_sync_slot #(
  parameter int           W        = 13,
  parameter int           SYNC_CYC = 4,
  parameter logic [W-1:0] INIT     = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o,
  output logic [W-1:0] q_o
);
  localparam int BC_W = $clog2(SYNC_CYC + 1);

  logic [W-1:0]    stage_q, q_q;
  logic [BC_W-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= INIT;
      q_q     <= INIT;
      bcnt_q  <= '0;
    end else if (load_i) begin
      stage_q <= val_i;
      bcnt_q  <= BC_W'(SYNC_CYC);
    end else if (tick_i && bcnt_q != '0) begin
      if (bcnt_q == BC_W'(1)) q_q <= stage_q;
      bcnt_q <= bcnt_q - 1'b1;
    end
  end

  assign busy_o = (bcnt_q != '0);
  assign q_o    = q_q;

  // R4
  busy_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  // R11
  busy_holds_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(q_o)));
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 12,
  parameter int DIV_W    = 4,
  parameter int SYNC_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lsi_tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  psc_code_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ew_en_o,
  output logic [CNT_W-1:0]  ew_cmp_o,
  output logic              ew_clr_o,
  output logic              start_o,
  output logic              refresh_o,
  output logic              running_o
);
  localparam int SLOT_W = CNT_W + 1;

  function automatic logic [SLOT_W-1:0] slot_init(int ch);
    return (ch == CH_RLD) ? {1'b0, {CNT_W{1'b1}}} : '0;
  endfunction

  logic              unlocked_q, running_q, key_hit, cfg_we;
  logic [15:0]       key;
  logic [N_CH-1:0]   load, busy;
  logic [SLOT_W-1:0] val [N_CH];
  logic [SLOT_W-1:0] q   [N_CH];

  assign key     = wdata_i[15:0];
  assign key_hit = we_i && (addr_i == ADDR_W'(OFF_KEY));
  assign cfg_we  = we_i && unlocked_q;

  assign load[CH_PSC] = cfg_we && (addr_i == ADDR_W'(OFF_PSC));
  assign load[CH_RLD] = cfg_we && (addr_i == ADDR_W'(OFF_RLD));
  assign load[CH_EWC] = cfg_we && (addr_i == ADDR_W'(OFF_EWC));
  assign val[CH_PSC]  = SLOT_W'(wdata_i[DIV_W-1:0]);
  assign val[CH_RLD]  = SLOT_W'(wdata_i[CNT_W-1:0]);
  assign val[CH_EWC]  = {wdata_i[15], wdata_i[CNT_W-1:0]};

  assign start_o   = key_hit && (key == KEY_START);
  assign refresh_o = key_hit && (key == KEY_REFRESH);
  assign ew_clr_o  = load[CH_EWC] && wdata_i[14];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      if (key_hit) unlocked_q <= (key == KEY_UNLOCK);
      if (start_o) running_q  <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_slot
    kwd_sync_slot #(.W(SLOT_W), .SYNC_CYC(SYNC_CYC), .INIT(slot_init(i))) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (lsi_tick_i),
      .load_i (load[i]),
      .val_i  (val[i]),
      .busy_o (busy[i]),
      .q_o    (q[i])
    );
  end

  assign psc_code_o = q[CH_PSC][DIV_W-1:0];
  assign reload_o   = q[CH_RLD][CNT_W-1:0];
  assign ew_en_o    = q[CH_EWC][CNT_W];
  assign ew_cmp_o   = q[CH_EWC][CNT_W-1:0];
  assign running_o  = running_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_PSC)) rdata_o[DIV_W-1:0] = psc_code_o;
    if (addr_i == ADDR_W'(OFF_RLD)) rdata_o[CNT_W-1:0] = reload_o;
    if (addr_i == ADDR_W'(OFF_STAT)) rdata_o[3:0] = {busy[CH_EWC], 1'b0, busy[CH_RLD], busy[CH_PSC]};
    if (addr_i == ADDR_W'(OFF_EWC)) begin
      rdata_o[15]        = ew_en_o;
      rdata_o[CNT_W-1:0] = ew_cmp_o;
    end
  end

  // R2
  locked_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_q |=> !$rose(busy[CH_RLD]));
  // R5
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |=> running_q);
endmodule

// File: rtl/kwd_presc.sv
module kwd_presc #(
  parameter int DIV_W    = 4,
  parameter int MAX_CODE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             freeze_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             step_o
);
  localparam int PSC_W = MAX_CODE + 2;

  logic [PSC_W-1:0] cnt_q, last;
  logic             en;
  int               eff;

  always_comb begin
    eff  = (int'(code_i) > MAX_CODE) ? MAX_CODE : int'(code_i);
    last = PSC_W'((4 << eff) - 1);
  end

  assign en     = tick_i && run_i && !freeze_i;
  // >= keeps a shrinking divisor from overrunning the wrap point
  assign step_o = en && !clr_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en)     cnt_q <= step_o ? '0 : cnt_q + 1'b1;
  end

  // R10
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kwd_cnt.sv
module kwd_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ew_en_i,
  input  logic [CNT_W-1:0] ew_cmp_i,
  input  logic             ew_clr_i,
  output logic             rst_req_o,
  output logic             ew_irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q, ew_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= reload_i;
      req_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
      req_q <= (cnt_q == '0);
    end else begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ew_q <= 1'b0;
    else if (ew_clr_i) ew_q <= 1'b0;
    else if (step_i && !load_i && ew_en_i && cnt_q != '0 && (cnt_q - 1'b1) == ew_cmp_i)
      ew_q <= 1'b1;
  end

  assign rst_req_o = req_q;
  assign ew_irq_o  = ew_q && ew_en_i;

  // R8
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  // R9
  ew_rise_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ew_q) |-> $past(step_i));
endmodule

// File: rtl/kwd_top.sv
module kwd_top #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 12,
  parameter int DIV_W    = 4,
  parameter int MAX_CODE = 6,
  parameter int SYNC_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lsi_tick_i,
  input  logic              freeze_stop_i,
  input  logic              freeze_standby_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rst_req_o,
  output logic              ew_irq_o
);
  logic [DIV_W-1:0] psc_code;
  logic [CNT_W-1:0] reload, ew_cmp;
  logic             ew_en, ew_clr, start, refresh, running, step, load;

  assign load = start || refresh;

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W),
             .SYNC_CYC(SYNC_CYC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lsi_tick_i (lsi_tick_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .psc_code_o (psc_code),
    .reload_o   (reload),
    .ew_en_o    (ew_en),
    .ew_cmp_o   (ew_cmp),
    .ew_clr_o   (ew_clr),
    .start_o    (start),
    .refresh_o  (refresh),
    .running_o  (running)
  );

  kwd_presc #(.DIV_W(DIV_W), .MAX_CODE(MAX_CODE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (lsi_tick_i),
    .run_i    (running),
    .freeze_i (freeze_stop_i || freeze_standby_i),
    .clr_i    (load),
    .code_i   (psc_code),
    .step_o   (step)
  );

  kwd_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .load_i    (load),
    .reload_i  (reload),
    .ew_en_i   (ew_en),
    .ew_cmp_i  (ew_cmp),
    .ew_clr_i  (ew_clr),
    .rst_req_o (rst_req_o),
    .ew_irq_o  (ew_irq_o)
  );

  // R5
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !rst_req_o);
endmodule

// File: tb/kwd_top_tb.sv
module kwd_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        frz_stop = 1'b0;
  logic        frz_stby = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req, ew_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [4:0] A_KEY = 5'h00, A_PSC = 5'h04, A_RLD = 5'h08,
                         A_STAT = 5'h0C, A_EWC = 5'h14;

  // {code, reload, expected cycles from refresh to first request}
  localparam logic [31:0] VEC [8] = '{
    {4'd0,  12'd5, 16'd24},  {4'd1, 12'd3, 16'd32},
    {4'd2,  12'd2, 16'd48},  {4'd0, 12'd0, 16'd4},
    {4'd3,  12'd1, 16'd64},  {4'd7, 12'd0, 16'd256},
    {4'd6,  12'd1, 16'd512}, {4'd15, 12'd0, 16'd256}
  };

  always #4 clk = ~clk;

  kwd_top u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .lsi_tick_i       (tick),
    .freeze_stop_i    (frz_stop),
    .freeze_standby_i (frz_stby),
    .reg_we_i         (we),
    .reg_addr_i       (addr),
    .reg_wdata_i      (wdata),
    .reg_rdata_o      (rdata),
    .rst_req_o        (rst_req),
    .ew_irq_o         (ew_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from now until the first request, or -1 within lim
  task automatic first_req(input int lim, output int hit);
    hit = -1;
    for (int k = 1; k <= lim && hit < 0; k++) begin
      @(negedge clk);
      if (rst_req) hit = k;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [15:0] d;
    int hit, cnt_req, irq_at;
    bit seen;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1
    rd(A_PSC, d);  check("R1 psc", d, 16'h0);
    rd(A_RLD, d);  check("R1 rld", d, 16'hFFF);
    rd(A_EWC, d);  check("R1 ewc", d, 16'h0);
    rd(A_STAT, d); check("R1 stat", d, 16'h0);
    check("R1 outputs", {rst_req, ew_irq}, 2'b00);

    // R2 locked write ignored
    wr(A_RLD, 16'd5);
    rd(A_STAT, d); check("R2 locked stat", d, 16'h0);
    wait_n(5);
    rd(A_RLD, d);  check("R2 locked rld", d, 16'hFFF);

    // R2/R4 unlocked write with busy window
    wr(A_KEY, 16'h5555);
    wr(A_RLD, 16'd5);
    rd(A_STAT, d); check("R4 rld busy", d, 16'h2);
    rd(A_RLD, d);  check("R4 old value", d, 16'hFFF);
    wait_n(3);
    rd(A_STAT, d); check("R4 busy at 3", d, 16'h2);
    wait_n(1);
    rd(A_STAT, d); check("R4 busy clear", d, 16'h0);
    rd(A_RLD, d);  check("R2 rld applied", d, 16'd5);

    // R11 busy stalls without ticks
    @(negedge clk); tick = 1'b0;
    wr(A_PSC, 16'd2);
    wait_n(10);
    rd(A_STAT, d); check("R11 psc busy stalled", d, 16'h1);
    rd(A_PSC, d);  check("R11 psc old", d, 16'h0);
    tick = 1'b1;
    wait_n(4);
    rd(A_STAT, d); check("R11 psc clear", d, 16'h0);
    rd(A_PSC, d);  check("R11 psc applied", d, 16'd2);
    wr(A_PSC, 16'd0);
    wait_n(4);

    // R3 other keys re-lock
    wr(A_KEY, 16'h1234);
    wr(A_RLD, 16'd7);
    wait_n(5);
    rd(A_RLD, d);  check("R3 relock other", d, 16'd5);
    wr(A_KEY, 16'h5555);
    wr(A_KEY, 16'hAAAA);
    wr(A_RLD, 16'd9);
    wait_n(5);
    rd(A_RLD, d);  check("R3 relock refresh", d, 16'd5);

    // R5 idle before start
    seen = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    check("R5 no request before start", seen, 1'b0);

    // R9 early warning at compare 2
    wr(A_KEY, 16'h5555);
    wr(A_EWC, 16'h8002);
    wait_n(5);
    rd(A_EWC, d);  check("R9 ewc readback", d, 16'h8002);

    // R5/R6/R8/R9 start and observe two periods
    wr(A_KEY, 16'hCCCC);
    hit = -1; irq_at = -1; cnt_req = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (ew_irq && irq_at < 0) irq_at = k;
      if (rst_req) begin
        cnt_req++;
        if (hit < 0) hit = k;
      end
    end
    check("R9 irq step", irq_at, 12);
    check("R6 first expiry", hit, 24);
    check("R8 two one-cycle pulses", cnt_req, 2);
    check("R9 irq sticky", ew_irq, 1'b1);

    // R9 clear and disable
    wr(A_KEY, 16'h5555);
    wr(A_EWC, 16'h4002);
    check("R9 clear immediate", ew_irq, 1'b0);
    wait_n(5);
    seen = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (ew_irq) seen = 1'b1;
    end
    check("R9 disabled stays low", seen, 1'b0);

    // R7 refresh restarts period
    wr(A_KEY, 16'hAAAA);
    first_req(100, hit);
    check("R7 refresh period", hit, 24);
    seen = 1'b0;
    for (int r = 0; r < 6; r++) begin
      wr(A_KEY, 16'hAAAA);
      for (int k = 0; k < 18; k++) begin
        @(negedge clk);
        if (rst_req) seen = 1'b1;
      end
    end
    check("R7 frequent refresh", seen, 1'b0);

    // R10 stop freeze for 10 ticks
    wr(A_KEY, 16'hAAAA);
    hit = -1;
    for (int k = 1; k <= 100 && hit < 0; k++) begin
      @(negedge clk);
      if (rst_req) hit = k;
      if (k == 5)  frz_stop = 1'b1;
      if (k == 15) frz_stop = 1'b0;
    end
    check("R10 stop freeze", hit, 34);

    // R10 standby freeze
    wr(A_KEY, 16'hAAAA);
    hit = -1;
    for (int k = 1; k <= 100 && hit < 0; k++) begin
      @(negedge clk);
      if (rst_req) hit = k;
      if (k == 5)  frz_stby = 1'b1;
      if (k == 15) frz_stby = 1'b0;
    end
    check("R10 standby freeze", hit, 34);

    // R6 table of prescaler/reload settings
    for (int v = 0; v < 8; v++) begin
      wr(A_KEY, 16'h5555);
      wr(A_PSC, 16'(VEC[v][31:28]));
      wr(A_RLD, 16'(VEC[v][27:16]));
      wait_n(5);
      wr(A_KEY, 16'hAAAA);
      first_req(600, hit);
      check($sformatf("R6 vector %0d", v), hit, 32'(VEC[v][15:0]));
    end

    // R5 cannot be stopped
    wr(A_KEY, 16'h0000);
    wr(A_KEY, 16'h5555);
    first_req(300, hit);
    check("R5 still running", hit > 0, 1'b1);

    done = 1'b1;
    summary();
  end
endmodule